// File: doc/BRIEF.md
# Stop Mode Wake-Up Sequencer

This block parks a small microcontroller-style system in a low-power stop state and later brings it back out. While the system runs, a stop request from the core makes the sequencer drop the clock enables to the CPU and to the peripherals. It then waits for a wake event. A module interrupt or a break request ends the stop. The system reset also ends it, and reset overrides everything else.

The block does not release the clocks at once when a wake event arrives. It first times a recovery interval with an internal counter that runs on the free-running input clock. That counter is held at zero for the whole time the system is stopped and is reused to time the recovery. A short-recovery configuration bit selects the length of the interval, and the block samples it when it accepts the stop. At the end of recovery the clocks come back on, and a one-cycle pulse tells the core it may begin interrupt stacking.

A sticky status flag records that a break request caused the wake. The core clears it by writing a 1 through a write strobe. All pins are plain control and status levels or strobes. No data stream passes through the block, so no valid/ready handshake is involved.

Top module: `stop_wake_seq`

## Requirements
- R1: In the run state, a high `stop_req` at a rising edge is accepted. From the next cycle, `clk_en_cpu` and `clk_en_per` are low.
- R2: While stopped, a high `irq_req` or `brk_req` at a rising edge starts recovery. The clock enables stay low until recovery completes.
- R3: The recovery counter reads zero for the whole stop state. It counts up from zero only during recovery.
- R4: Counted from the edge that samples the wake source, the clock enables rise exactly LONG_CYCLES (default 4096) cycles later when the sampled configuration bit is 0. They rise SHORT_CYCLES (default 32) cycles later when the bit is 1.
- R5: `short_rec` is sampled only at the edge that accepts the stop request. Changes to it during stop or recovery do not alter the recovery length.
- R6: `stack_start` is high for exactly one cycle, the first cycle with the clocks enabled after a recovery. At all other times it is low.
- R7: A `brk_req` sampled while stopped sets `brk_stop_flag`. The flag stays set until a rising edge with `flag_wr`=1 and `flag_wdata`=1. If a set and a clear fall in the same cycle, the set wins.
- R8: `rst_n` low asynchronously returns the block to the run state. Both clock enables go high, `brk_stop_flag` clears and `stack_start` is low. Leaving reset produces no `stack_start` pulse.
- R9: A `stop_req` during stop or recovery is ignored. It neither restarts nor extends the recovery.
- R10: In the run state, `irq_req` and `brk_req` have no effect. The clocks stay enabled, no pulse is produced and `brk_stop_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake source |
| stop_req | input | 1 | Stop request from the core |
| irq_req | input | 1 | Module interrupt request (wake source) |
| brk_req | input | 1 | Break request (wake source, sets status) |
| short_rec | input | 1 | 1 selects short recovery, 0 selects long recovery |
| flag_wr | input | 1 | Status write strobe |
| flag_wdata | input | 1 | Write data; 1 clears the break flag |
| clk_en_cpu | output | 1 | Clock enable to the CPU |
| clk_en_per | output | 1 | Clock enable to the peripherals |
| stack_start | output | 1 | One-cycle pulse: begin interrupt stacking |
| brk_stop_flag | output | 1 | Sticky break-caused-wake status |

## Verification
The bench counts the exact number of cycles with the clocks gated for both recovery lengths. An off-by-one in the terminal count would show up as 4095, 4097, 31 or 33. It toggles `short_rec` and pulses `stop_req` in the middle of recovery. A design that sampled the bit late or let the request restart the counter would produce the wrong length. It resets the block in the middle of stop and in the middle of recovery and then watches for a stray `stack_start`. It also clears the break flag in the same cycle as a break, where a design with the wrong priority would lose the flag.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [1:0] {
    SW_RUN     = 2'd0,
    SW_STOP    = 2'd1,
    SW_RECOVER = 2'd2
  } sw_state_e;
endpackage

// File: rtl/sw_rec_counter.sv
module sw_rec_counter #(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32,
  localparam int CNT_W = $clog2(LONG_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,       // count when high, hold at zero when low
  input  logic             use_short,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

  logic [CNT_W-1:0] last;

  assign last = use_short ? SHORT_LAST : LONG_LAST;
  assign done = run && (count == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!run||done) count <= '0;
    else                 count <= count + 1'b1;
  end
endmodule

// File: rtl/sw_brk_status.sv
module sw_brk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr,
  input  logic wdata,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (set)        flag <= 1'b1;   // set beats write-one-to-clear
    else if (wr && wdata) flag <= 1'b0;
  end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq #(
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32,
  localparam int CNT_W = $clog2(LONG_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic irq_req,
  input  logic brk_req,
  input  logic short_rec,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic clk_en_cpu,
  output logic clk_en_per,
  output logic stack_start,
  output logic brk_stop_flag
);
  import stop_wake_pkg::*;

  sw_state_e        state_q, state_d;
  logic             short_q;
  logic [CNT_W-1:0] rec_cnt;
  logic             rec_done;
  logic             wake;
  logic             pulse_q;

  assign wake = irq_req || brk_req;

  sw_rec_counter #(
    .LONG_CYCLES (LONG_CYCLES),
    .SHORT_CYCLES(SHORT_CYCLES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q == SW_RECOVER),
    .use_short(short_q),
    .count    (rec_cnt),
    .done     (rec_done)
  );

  sw_brk_status u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ((state_q == SW_STOP) && brk_req),
    .wr   (flag_wr),
    .wdata(flag_wdata),
    .flag (brk_stop_flag)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_RUN:     if (stop_req) state_d = SW_STOP;
      SW_STOP:    if (wake)     state_d = SW_RECOVER;
      SW_RECOVER: if (rec_done) state_d = SW_RUN;
      default:                  state_d = SW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_RUN;
      short_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q == SW_RECOVER) && rec_done;
      if (state_q == SW_RUN && stop_req) short_q <= short_rec;
    end
  end

  assign clk_en_cpu  = (state_q == SW_RUN);
  assign clk_en_per  = (state_q == SW_RUN);
  assign stack_start = pulse_q;
endmodule

// File: rtl/stop_wake_seq_chk.sv
module stop_wake_seq_chk
  import stop_wake_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             irq_req,
  input logic             brk_req,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic             clk_en_cpu,
  input logic             clk_en_per,
  input logic             stack_start,
  input logic             brk_stop_flag,
  input sw_state_e        st,
  input logic [CNT_W-1:0] cnt
);
  p_enter_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_cpu && stop_req) |=> (!clk_en_cpu && !clk_en_per));

  p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SW_RUN) |-> (!clk_en_cpu && !clk_en_per));

  p_cnt_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_STOP) |-> (cnt == '0));

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_start |=> !stack_start);

  p_pulse_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_start |-> clk_en_cpu);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stop_flag && !(flag_wr && flag_wdata)) |=> brk_stop_flag);

  p_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_STOP && !irq_req && !brk_req) |=> (st == SW_STOP));

  p_run_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_cpu && !stop_req) |=> clk_en_cpu);
endmodule

bind stop_wake_seq stop_wake_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_req     (stop_req),
  .irq_req      (irq_req),
  .brk_req      (brk_req),
  .flag_wr      (flag_wr),
  .flag_wdata   (flag_wdata),
  .clk_en_cpu   (clk_en_cpu),
  .clk_en_per   (clk_en_per),
  .stack_start  (stack_start),
  .brk_stop_flag(brk_stop_flag),
  .st           (state_q),
  .cnt          (rec_cnt)
);

// File: tb/stop_wake_seq_tb.sv
`timescale 1ns/1ps
module stop_wake_seq_tb;
  localparam int LONG_C  = 4096;
  localparam int SHORT_C = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, irq_req = 0, brk_req = 0, short_rec = 0;
  logic flag_wr = 0, flag_wdata = 0;
  logic clk_en_cpu, clk_en_per, stack_start, brk_stop_flag;

  int errors = 0;
  int checks = 0;
  logic exp_flag = 0;

  always #10 clk = ~clk;

  stop_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
    .brk_req(brk_req), .short_rec(short_rec), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .clk_en_cpu(clk_en_cpu), .clk_en_per(clk_en_per),
    .stack_start(stack_start), .brk_stop_flag(brk_stop_flag)
  );

  function automatic int rec_len(input logic s);
    return s ? SHORT_C : LONG_C;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Enter stop, wake, count gated cycles. src: 0 irq, 1 brk
  task automatic stop_cycle(input logic cfg, input logic src, input int idle,
                            input logic disturb);
    int n;
    tick();
    short_rec = cfg; stop_req = 1;
    tick();
    stop_req = 0; short_rec = ~cfg;
    check("R1 clk_en_cpu off", clk_en_cpu, 0);
    check("R1 clk_en_per off", clk_en_per, 0);
    for (int i = 0; i < idle; i++) begin
      stop_req = (i % 3 == 1);          // R9: ignored in stop
      tick();
      check("R2 gated while stopped", clk_en_cpu, 0);
    end
    stop_req = 0;
    if (src) brk_req = 1; else irq_req = 1;
    tick();                             // wake sampled at the edge before this
    irq_req = 0; brk_req = 0;
    if (src) exp_flag = 1;
    n = 0;
    while (!clk_en_cpu && n < LONG_C + 10) begin
      n++;
      if (disturb) begin
        short_rec = n[0];               // R5: ignored after acceptance
        stop_req = (n == 5);            // R9: ignored in recovery
      end
      check("R6 no early pulse", stack_start, 0);
      tick();
    end
    stop_req = 0;
    check(cfg ? "R4 short length" : "R4 long length", n, rec_len(cfg));
    check("R2 clocks back", clk_en_per, 1);
    check("R6 pulse high", stack_start, 1);
    check("R7 flag value", brk_stop_flag, exp_flag);
    tick();
    check("R6 pulse single", stack_start, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick();
    check("R8 reset clk_en", clk_en_cpu, 1);
    check("R8 reset flag", brk_stop_flag, 0);
    check("R8 reset pulse", stack_start, 0);
    rst_n = 1;
    tick();

    // R10: wake sources in run have no effect
    irq_req = 1; brk_req = 1;
    tick(); tick();
    irq_req = 0; brk_req = 0;
    check("R10 clocks stay on", clk_en_cpu, 1);
    check("R10 no pulse", stack_start, 0);
    check("R10 flag untouched", brk_stop_flag, 0);

    // directed: short and long, with disturbance during recovery (R5, R9)
    stop_cycle(1'b1, 1'b0, 4, 1'b1);
    stop_cycle(1'b0, 1'b0, 2, 1'b1);
    stop_cycle(1'b1, 1'b1, 1, 1'b0);   // break wake sets flag (R7)

    // R7: clear via write strobe
    flag_wr = 1; flag_wdata = 0;
    tick();
    check("R7 write zero keeps flag", brk_stop_flag, 1);
    flag_wdata = 1;
    tick();
    flag_wr = 0; flag_wdata = 0; exp_flag = 0;
    check("R7 write one clears", brk_stop_flag, 0);

    // R7: set wins over simultaneous clear
    stop_req = 1; short_rec = 1;
    tick();
    stop_req = 0;
    brk_req = 1; flag_wr = 1; flag_wdata = 1;
    tick();
    brk_req = 0; flag_wr = 0; flag_wdata = 0; exp_flag = 1;
    check("R7 set beats clear", brk_stop_flag, 1);
    for (int i = 0; i < SHORT_C + 2; i++) tick();
    check("R7 recovered", clk_en_cpu, 1);

    // R8: reset in stop and in recovery, no stray pulse
    stop_req = 1;
    tick();
    stop_req = 0;
    tick();
    rst_n = 0; #1;
    check("R8 async run in stop", clk_en_cpu, 1);
    check("R8 flag cleared", brk_stop_flag, 0);
    exp_flag = 0;
    tick(); rst_n = 1;
    stop_req = 1; short_rec = 1;
    tick();
    stop_req = 0; irq_req = 1;
    tick();
    irq_req = 0;
    for (int i = 0; i < 10; i++) tick();
    rst_n = 0; #1;
    check("R8 async run in recovery", clk_en_per, 1);
    tick(); rst_n = 1;
    begin
      int pulses = 0;
      for (int i = 0; i < SHORT_C + 5; i++) begin
        tick();
        if (stack_start) pulses++;
      end
      check("R8 no pulse after reset", pulses, 0);
    end

    // random mix
    for (int k = 0; k < 8; k++) begin
      logic cfg, src, dis;
      int idle;
      cfg  = ($urandom % 4) != 0;
      src  = $urandom % 2;
      dis  = $urandom % 2;
      idle = $urandom % 20;
      stop_cycle(cfg, src, idle, dis);
      if ($urandom % 2) begin
        flag_wr = 1; flag_wdata = 1;
        tick();
        flag_wr = 0; flag_wdata = 0; exp_flag = 0;
        check("R7 random clear", brk_stop_flag, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule